// File: doc/BRIEF.md
# Reference-Match Clock Divider

An 8-bit timer that divides a clock by comparing a running count with a programmable reference value. The count advances on a chosen source. That source is either a one-cycle tick from an internal prescaler or the edges of an external clock pin, and the detected edge polarity can be selected. When the count equals the reference, the next count event returns the count to zero and flips a toggle flip-flop. The toggle output therefore has a period of 2×(reference+1) count events. With a reference of 1 and rising-edge counting, the output runs at a quarter of the external input rate.

The toggle goes straight to a serial-interface clock tap. It also drives a shared output pin through a gate: the pin shows the divided clock only when the pin-enable flag is set and the pin's port latch is held at 0. Software programs the block through a small write port that holds a mode byte, a reference byte and a control byte. The mode byte and reference byte read back.

Top module: `refmatch_clkdiv`

## Requirements
- R1: On reset, the count is 0, the toggle output is 0, the mode byte reads 00h, the reference reads FFh, the pin-enable flag is 0 and pin_out is 0.
- R2: Mode bit 6 picks the count source: 0 selects edges of ext_clk_in, 1 selects int_tick (one event per clock cycle where it is high). The source that is not selected has no effect on the count.
- R3: Mode bits 5:4 pick the external edge that counts: 00 rising, 01 falling, 10 or 11 both edges. ext_clk_in passes through a two-flop synchronizer before edge detection.
- R4: On each count event the count increments. An event that arrives while the count equals the active reference instead clears the count and inverts the toggle, so the toggle period is 2×(reference+1) events.
- R5: Mode bit 3 enables counting. While it is 0, count events change neither the count nor the toggle.
- R6: Writing a mode byte with bit 2 set clears the count and the toggle and makes the current reference active. Bit 2 always reads back as 0, and the other mode bits read back as written.
- R7: A reference write (address 1) reads back at once, but it replaces the active reference only at the next match or clear, so the period in progress runs to its full old length.
- R8: pin_out is registered. One cycle after the inputs change, it equals pin-enable AND (toggle OR port_latch). The pin-enable flag is bit 0 of address 2.
- R9: sio_clk carries the toggle whatever the value of the pin-enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mode, 1 reference, 2 control |
| wr_data | input | 8 | Write data |
| ext_clk_in | input | 1 | External clock input, asynchronous |
| int_tick | input | 1 | Internal prescaled count tick |
| port_latch | input | 1 | Output latch of the shared pin |
| mode_rd | output | 8 | Mode byte readback |
| ref_rd | output | 8 | Reference byte readback |
| count_rd | output | 8 | Current count |
| sio_clk | output | 1 | Toggle output to the serial clock selector |
| pin_out | output | 1 | Gated divided clock on the shared pin |

## Verification
Because the divider state is 8 bits plus one toggle bit, any wrong count or active reference shows up on count_rd in the same cycle. It then shows on sio_clk at the next match, within at most 256 count events. An external edge reaches count_rd three clock edges after it is sampled, so each check waits a few cycles after the last stimulus. A stale active reference, for example one updated too early, shows up as a period that is cut short, and this is visible as a count that never reaches the old limit. A bad pin gate shows on pin_out one cycle after the pin-enable flag, port_latch or the toggle changes.

// File: rtl/refmatch_pkg.sv
package refmatch_pkg;
  localparam int MODE_W = 8;
  localparam int BIT_SRC_INT = 6;
  localparam int BIT_EDGE_HI = 5;
  localparam int BIT_EDGE_LO = 4;
  localparam int BIT_RUN = 3;
  localparam int BIT_CLR = 2;

  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_REF  = 2'd1,
    ADDR_CTRL = 2'd2
  } reg_addr_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_BOTH_ALT = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/refmatch_edge.sv
module refmatch_edge
  import refmatch_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic [1:0] edge_sel,
  output logic       evt
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;
  logic            lvl, prev, rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign prev = sh[STAGES];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    case (edge_sel)
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      default:   evt = rise | fall;
    endcase
  end
endmodule

// File: rtl/refmatch_regs.sv
module refmatch_regs
  import refmatch_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] REF_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [MODE_W-1:0] mode_q,
  output logic [W-1:0]      ref_q,
  output logic              oe_q,
  output logic              clr_o
);
  logic wr_mode, wr_ref, wr_ctrl;
  logic [MODE_W-1:0] mode_in;

  assign wr_mode = wr_en && (wr_addr == ADDR_MODE);
  assign wr_ref  = wr_en && (wr_addr == ADDR_REF);
  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);

  always_comb begin
    mode_in = '0;
    for (int i = 0; i < MODE_W; i++) begin
      if (i < W) mode_in[i] = wr_data[i];
    end
  end

  // Clear strobe acts at the same edge as the mode write
  assign clr_o = wr_mode && mode_in[BIT_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ref_q  <= REF_RST;
      oe_q   <= 1'b0;
    end else begin
      if (wr_mode) begin
        mode_q <= mode_in;
        mode_q[BIT_CLR] <= 1'b0;
      end
      if (wr_ref)  ref_q <= wr_data;
      if (wr_ctrl) oe_q  <= wr_data[0];
    end
  end
endmodule

// File: rtl/refmatch_core.sv
module refmatch_core #(
  parameter int W = 8,
  parameter logic [W-1:0] REF_RST = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         evt,
  input  logic [W-1:0] ref_in,
  output logic [W-1:0] cnt_q,
  output logic         tog_q,
  output logic [W-1:0] ref_act_q
);
  logic hit;
  assign hit = (cnt_q == ref_act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      tog_q     <= 1'b0;
      ref_act_q <= REF_RST;
    end else if (clr) begin
      cnt_q     <= '0;
      tog_q     <= 1'b0;
      ref_act_q <= ref_in;
    end else if (evt) begin
      if (hit) begin
        cnt_q     <= '0;
        tog_q     <= ~tog_q;
        ref_act_q <= ref_in;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/refmatch_clkdiv.sv
module refmatch_clkdiv
  import refmatch_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              ext_clk_in,
  input  logic              int_tick,
  input  logic              port_latch,
  output logic [MODE_W-1:0] mode_rd,
  output logic [W-1:0]      ref_rd,
  output logic [W-1:0]      count_rd,
  output logic              sio_clk,
  output logic              pin_out
);
  localparam logic [W-1:0] REF_RST = {W{1'b1}};

  logic [MODE_W-1:0] mode_q;
  logic [W-1:0]      ref_q, cnt_q, ref_act;
  logic              oe_q, clr, ext_evt, src_evt, evt, tog_q, pin_q;

  refmatch_regs #(.W(W), .REF_RST(REF_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_q(mode_q), .ref_q(ref_q), .oe_q(oe_q),
    .clr_o(clr)
  );

  refmatch_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .din(ext_clk_in),
    .edge_sel(mode_q[BIT_EDGE_HI:BIT_EDGE_LO]), .evt(ext_evt)
  );

  assign src_evt = mode_q[BIT_SRC_INT] ? int_tick : ext_evt;
  assign evt     = mode_q[BIT_RUN] & src_evt;

  refmatch_core #(.W(W), .REF_RST(REF_RST)) u_core (
    .clk(clk), .rst(rst), .clr(clr), .evt(evt), .ref_in(ref_q),
    .cnt_q(cnt_q), .tog_q(tog_q), .ref_act_q(ref_act)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= oe_q & (tog_q | port_latch);
  end

  assign mode_rd  = mode_q;
  assign ref_rd   = ref_q;
  assign count_rd = cnt_q;
  assign sio_clk  = tog_q;
  assign pin_out  = pin_q;
endmodule

// File: rtl/refmatch_clkdiv_chk.sv
module refmatch_clkdiv_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] cnt,
  input logic [W-1:0] ref_act,
  input logic         tog,
  input logic [7:0]   mode,
  input logic         oe,
  input logic         latch,
  input logic         pin,
  input logic         clr,
  input logic         evt
);
  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= ref_act);

  // R4
  toggle_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tog != $past(tog)) && !$past(clr) |-> (cnt == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode[3] && !clr) |=> ($stable(cnt) && $stable(tog)));

  // R6
  clr_bit_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mode[2]);

  // R8
  pin_off_chk: assert property (@(posedge clk) disable iff (rst)
    !oe |=> !pin);

  // R8
  pin_latch_high_chk: assert property (@(posedge clk) disable iff (rst)
    (oe && latch) |=> pin);

  // R4
  no_evt_no_move_chk: assert property (@(posedge clk) disable iff (rst)
    (!evt && !clr) |=> $stable(cnt));
endmodule

bind refmatch_clkdiv refmatch_clkdiv_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .ref_act(ref_act), .tog(tog_q),
  .mode(mode_q), .oe(oe_q), .latch(port_latch), .pin(pin_q),
  .clr(clr), .evt(evt)
);

// File: tb/refmatch_clkdiv_bench.sv
module refmatch_clkdiv_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ext_clk_in = 1'b0;
  logic       int_tick = 1'b0;
  logic       port_latch = 1'b0;
  logic [7:0] mode_rd, ref_rd, count_rd;
  logic       sio_clk, pin_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refmatch_clkdiv u_refmatch_clkdiv (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_clk_in(ext_clk_in), .int_tick(int_tick),
    .port_latch(port_latch), .mode_rd(mode_rd), .ref_rd(ref_rd),
    .count_rd(count_rd), .sio_clk(sio_clk), .pin_out(pin_out)
  );

  // fields: reference, mode, pulses, expected count, expected toggle
  localparam logic [39:0] VEC [0:5] = '{
    40'h01_0C_04_00_00,
    40'h01_0C_03_01_01,
    40'h03_1C_05_01_01,
    40'h02_2C_04_02_00,
    40'h00_0C_05_00_01,
    40'h04_3C_03_01_01
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int p = 0; p < n; p++) begin
      ext_clk_in = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk_in = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int t1, t2, seen;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count_rd, 0);
    chk("R1 toggle", sio_clk, 0);
    chk("R1 mode", mode_rd, 8'h00);
    chk("R1 reference", ref_rd, 8'hFF);
    chk("R1 pin", pin_out, 0);

    // table walk, pin enable left 0 (R3, R4, R9)
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, VEC[i][39:32]);
      wr(2'd0, VEC[i][31:24]);
      pulses(int'(VEC[i][23:16]));
      chk($sformatf("R4/R3 vec%0d count", i), count_rd, int'(VEC[i][15:8]));
      chk($sformatf("R4/R3 vec%0d toggle", i), sio_clk, int'(VEC[i][7:0]));
      chk($sformatf("R9 vec%0d pin stays low", i), pin_out, 0);
    end

    // R6 clear bit reads back 0, others as written
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h4C);
    chk("R6 mode readback", mode_rd, 8'h48);
    // R2 internal source: external edges ignored
    pulses(3);
    chk("R2 ext ignored", count_rd, 0);
    @(negedge clk); int_tick = 1'b1;
    repeat (7) @(negedge clk);
    int_tick = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 int count", count_rd, 1);
    chk("R2 int toggle", sio_clk, 0);
    // R2 external source: int_tick ignored
    wr(2'd0, 8'h0C);
    @(negedge clk); int_tick = 1'b1;
    repeat (5) @(negedge clk);
    int_tick = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 tick ignored", count_rd, 0);

    // R5 counting disabled
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h04);
    pulses(3);
    chk("R5 disabled count", count_rd, 0);
    chk("R5 disabled toggle", sio_clk, 0);

    // R7 reference change mid period
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h0C);
    pulses(2);
    chk("R7 before write", count_rd, 2);
    wr(2'd1, 8'h00);
    chk("R7 readback", ref_rd, 0);
    pulses(1);
    chk("R7 old limit kept", count_rd, 3);
    pulses(1);
    chk("R7 match count", count_rd, 0);
    chk("R7 match toggle", sio_clk, 1);
    pulses(1);
    chk("R7 new ref toggle", sio_clk, 0);

    // R4 divide by four: toggle period 4 input periods of 8 cycles
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h0C);
    t1 = -1; t2 = -1; seen = 0; prev = sio_clk;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      ext_clk_in = ((c % 8) < 4);
      if (sio_clk && !prev) begin
        if (seen == 0) t1 = c; else if (seen == 1) t2 = c;
        seen++;
      end
      prev = sio_clk;
    end
    ext_clk_in = 1'b0;
    chk("R4 quarter-rate period", t2 - t1, 32);

    // R8 pin gating: force toggle 1 then stop counting
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h0C);
    pulses(1);
    wr(2'd0, 8'h00);
    chk("R8 toggle held", sio_clk, 1);
    port_latch = 1'b0;
    wr(2'd2, 8'h00);
    repeat (2) @(negedge clk);
    chk("R8 disabled pin", pin_out, 0);
    wr(2'd2, 8'h01);
    repeat (2) @(negedge clk);
    chk("R8 pin follows toggle", pin_out, 1);
    wr(2'd0, 8'h04);
    repeat (2) @(negedge clk);
    chk("R8 pin after clear", pin_out, 0);
    port_latch = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 latch forces high", pin_out, 1);
    wr(2'd2, 8'h00);
    repeat (2) @(negedge clk);
    chk("R8 enable off with latch", pin_out, 0);

    // R1 mid-run reset
    wr(2'd1, 8'h07);
    wr(2'd0, 8'h4C);
    @(negedge clk); int_tick = 1'b1;
    repeat (3) @(negedge clk);
    int_tick = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rerun count", count_rd, 0);
    chk("R1 rerun reference", ref_rd, 8'hFF);
    chk("R1 rerun mode", mode_rd, 0);
    finish_run();
  end
endmodule